// File: doc/BRIEF.md
# OFDM Preamble Frame Detector

This block watches a stream of complex baseband samples for the repeating short-training section at the head of an OFDM packet. For every accepted sample it keeps two running quantities over the newest 32 samples. One is a lag-16 autocorrelation P: the sum of conj(r(t-16-m)) times r(t-m) for m = 0..15, with r(t) the newest sample. The other is the energy Q of the newest 16 samples. The block tests |P|^2 against a programmable fraction of Q^2 by cross-multiplication, so no divider is needed.

A frame is declared once the correlation test has passed on a long unbroken run of samples. From the next sample on, the block looks for the first sample where the metric falls below a second, lower threshold. That sample marks the end of the short-training section and gives the symbol timing. After that the detector ignores the stream until it is restarted, so a later packet cannot disturb the current one. The reported sample index lets downstream logic line up its symbol windows.

Top module: `frame_sync_det`

## Requirements
- R1: After reset, and on the cycle after a one-cycle `restart`, `det_flag` and `sync_pulse` are 0 and `idx_out` is 0. All sample history is zero, and sample numbering restarts at 0 with the next accepted sample.
- R2: With r(t) the sample of index t, and samples before index 0 taken as zero, the block evaluates P(t) = sum over m=0..15 of conj(r(t-16-m))·r(t-m) and Q(t) = sum over m=0..15 of |r(t-m)|^2 for every accepted sample t.
- R3: Sample t is detect-qualified when |P|^2·2^TH_FRAC > thr_det·Q^2 (strict). thr_det is unsigned with TH_FRAC = 6 fraction bits, so a value of 64 means 1.0.
- R4: In the search state the block counts consecutive detect-qualified samples, and any non-qualified sample clears the count. When the RUN_LEN-th (48) consecutive qualified sample arrives, `det_flag` rises and `idx_out` takes that sample's index.
- R5: After detection, the first later sample with |P|^2·2^TH_FRAC < thr_syn·Q^2 (strict, same format) gives a one-cycle `sync_pulse`, and `idx_out` takes that sample's index.
- R6: After the sync pulse, no further detection or sync event occurs and `det_flag` stays 1 until `restart`.
- R7: Full-scale 12-bit samples, including -2048 on both rails, give exact results: no internal sum or product wraps.
- R8: Only cycles with `smp_vld` high advance the sample stream. Idle cycles between samples do not change any result.
- R9: A `det_flag` rise or a `sync_pulse` appears on the third clock edge after the edge that accepted the deciding sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| restart | input | 1 | re-arms the detector and clears history |
| smp_vld | input | 1 | sample strobe |
| smp_i | input | SMP_W | signed in-phase sample |
| smp_q | input | SMP_W | signed quadrature sample |
| thr_det | input | TH_W | detection threshold, TH_FRAC fraction bits |
| thr_syn | input | TH_W | timing threshold, TH_FRAC fraction bits |
| det_flag | output | 1 | frame detected, held until restart |
| sync_pulse | output | 1 | one-cycle timing strobe |
| idx_out | output | IDX_W | index of the sample that caused the last event |

## Verification
The bench builds the block with its default parameters: 12-bit samples, lag 16, a 48-sample run and 6 fraction bits on the thresholds. These values bring the full-scale -2048 corner within reach, as well as the exact-equality case that a constant input produces. A constant input makes |P|^2 equal Q^2 once the window is full, so a threshold of 64 tests the strict comparison of both tests exactly. Random gaps in the strobe, a broken run inside a preamble and a second preamble after timing is found cover the counting, ordering and lock-out rules.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_WAIT   = 2'd1,
    ST_DONE   = 2'd2
  } fsd_state_e;
endpackage

// File: rtl/fsd_corr.sv
// Sample history and running lag correlation / energy sums.
module fsd_corr #(
  parameter int SW    = 12,
  parameter int LAG   = 16,
  parameter int IDX_W = 16,
  localparam int LW   = $clog2(LAG),
  localparam int EW   = 2*SW+1,
  localparam int PW   = EW+LW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 restart,
  input  logic                 in_vld,
  input  logic signed [SW-1:0] in_re,
  input  logic signed [SW-1:0] in_im,
  output logic                 out_vld,
  output logic signed [PW-1:0] p_re,
  output logic signed [PW-1:0] p_im,
  output logic signed [PW-1:0] q_sum,
  output logic [IDX_W-1:0]     out_idx
);
  localparam int DEPTH = 2*LAG;

  logic signed [SW-1:0] h_re [DEPTH];
  logic signed [SW-1:0] h_im [DEPTH];
  logic [IDX_W-1:0]     smp_cnt;

  // real part of conj(a)*b
  function automatic logic signed [EW-1:0] dot_re(
    input logic signed [SW-1:0] ar, input logic signed [SW-1:0] ai,
    input logic signed [SW-1:0] br, input logic signed [SW-1:0] bi);
    logic signed [EW-1:0] xa, xb, ya, yb;
    xa = {{(SW+1){ar[SW-1]}}, ar};
    xb = {{(SW+1){ai[SW-1]}}, ai};
    ya = {{(SW+1){br[SW-1]}}, br};
    yb = {{(SW+1){bi[SW-1]}}, bi};
    return xa*ya + xb*yb;
  endfunction

  // imaginary part of conj(a)*b
  function automatic logic signed [EW-1:0] dot_im(
    input logic signed [SW-1:0] ar, input logic signed [SW-1:0] ai,
    input logic signed [SW-1:0] br, input logic signed [SW-1:0] bi);
    logic signed [EW-1:0] xa, xb, ya, yb;
    xa = {{(SW+1){ar[SW-1]}}, ar};
    xb = {{(SW+1){ai[SW-1]}}, ai};
    ya = {{(SW+1){br[SW-1]}}, br};
    yb = {{(SW+1){bi[SW-1]}}, bi};
    return xa*yb - xb*ya;
  endfunction

  function automatic logic signed [PW-1:0] widen(input logic signed [EW-1:0] v);
    return {{LW{v[EW-1]}}, v};
  endfunction

  // history shift: h[0] is the previous sample, h[DEPTH-1] the oldest
  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst || restart) begin
          h_re[g] <= '0;
          h_im[g] <= '0;
        end else if (in_vld) begin
          h_re[g] <= in_re;
          h_im[g] <= in_im;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst || restart) begin
          h_re[g] <= '0;
          h_im[g] <= '0;
        end else if (in_vld) begin
          h_re[g] <= h_re[g-1];
          h_im[g] <= h_im[g-1];
        end
      end
    end
  end

  logic signed [EW-1:0] c_in_re, c_in_im, c_out_re, c_out_im, e_in, e_out;

  always_comb begin
    // entering term: conj(r(t-16)) * r(t); leaving: conj(r(t-32)) * r(t-16)
    c_in_re  = dot_re(h_re[LAG-1], h_im[LAG-1], in_re, in_im);
    c_in_im  = dot_im(h_re[LAG-1], h_im[LAG-1], in_re, in_im);
    c_out_re = dot_re(h_re[DEPTH-1], h_im[DEPTH-1], h_re[LAG-1], h_im[LAG-1]);
    c_out_im = dot_im(h_re[DEPTH-1], h_im[DEPTH-1], h_re[LAG-1], h_im[LAG-1]);
    e_in     = dot_re(in_re, in_im, in_re, in_im);
    e_out    = dot_re(h_re[LAG-1], h_im[LAG-1], h_re[LAG-1], h_im[LAG-1]);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      p_re    <= '0;
      p_im    <= '0;
      q_sum   <= '0;
      smp_cnt <= '0;
      out_idx <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        p_re    <= p_re + widen(c_in_re) - widen(c_out_re);
        p_im    <= p_im + widen(c_in_im) - widen(c_out_im);
        q_sum   <= q_sum + widen(e_in) - widen(e_out);
        out_idx <= smp_cnt;
        smp_cnt <= smp_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsd_metric.sv
// Division-free threshold tests on the correlation metric.
module fsd_metric #(
  parameter int PW    = 29,
  parameter int TH_W  = 8,
  parameter int TF    = 6,
  parameter int IDX_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 restart,
  input  logic                 in_vld,
  input  logic signed [PW-1:0] p_re,
  input  logic signed [PW-1:0] p_im,
  input  logic signed [PW-1:0] q_sum,
  input  logic [IDX_W-1:0]     in_idx,
  input  logic [TH_W-1:0]      thr_det,
  input  logic [TH_W-1:0]      thr_syn,
  output logic                 out_vld,
  output logic                 qual_det,
  output logic                 qual_syn,
  output logic [IDX_W-1:0]     out_idx
);
  localparam int L_LHS = 2*PW + 1 + TF;
  localparam int L_RHS = TH_W + 2*PW;
  localparam int CW    = ((L_LHS > L_RHS) ? L_LHS : L_RHS) + 1;

  logic signed [CW-1:0] pr_x, pi_x, q_x, mag_s, rhs_det, rhs_syn, td_x, ts_x;

  always_comb begin
    pr_x    = CW'(p_re);
    pi_x    = CW'(p_im);
    q_x     = CW'(q_sum);
    td_x    = CW'(signed'({1'b0, thr_det}));
    ts_x    = CW'(signed'({1'b0, thr_syn}));
    mag_s   = (pr_x*pr_x + pi_x*pi_x) <<< TF;
    rhs_det = td_x * q_x * q_x;
    rhs_syn = ts_x * q_x * q_x;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      out_vld  <= 1'b0;
      qual_det <= 1'b0;
      qual_syn <= 1'b0;
      out_idx  <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        qual_det <= mag_s > rhs_det;
        qual_syn <= mag_s < rhs_syn;
        out_idx  <= in_idx;
      end
    end
  end
endmodule

// File: rtl/fsd_ctrl.sv
// Run counter and search / wait / done sequencing.
module fsd_ctrl
  import fsd_pkg::*;
#(
  parameter int RUN_LEN = 48,
  parameter int IDX_W   = 16,
  localparam int CNT_W  = $clog2(RUN_LEN+1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             in_vld,
  input  logic             qual_det,
  input  logic             qual_syn,
  input  logic [IDX_W-1:0] in_idx,
  output logic             det_flag,
  output logic             sync_pulse,
  output logic [IDX_W-1:0] idx_out
);
  fsd_state_e       st;
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      st         <= ST_SEARCH;
      run_cnt    <= '0;
      det_flag   <= 1'b0;
      sync_pulse <= 1'b0;
      idx_out    <= '0;
    end else begin
      sync_pulse <= 1'b0;
      if (in_vld) begin
        unique case (st)
          ST_SEARCH: begin
            if (!qual_det) begin
              run_cnt <= '0;
            end else if (run_cnt == CNT_W'(RUN_LEN-1)) begin
              det_flag <= 1'b1;
              idx_out  <= in_idx;
              st       <= ST_WAIT;
            end else begin
              run_cnt <= run_cnt + 1'b1;
            end
          end
          ST_WAIT: begin
            if (qual_syn) begin
              sync_pulse <= 1'b1;
              idx_out    <= in_idx;
              st         <= ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/frame_sync_det.sv
module frame_sync_det #(
  parameter int SMP_W   = 12,
  parameter int LAG     = 16,
  parameter int RUN_LEN = 48,
  parameter int TH_W    = 8,
  parameter int TH_FRAC = 6,
  parameter int IDX_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    restart,
  input  logic                    smp_vld,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic signed [SMP_W-1:0] smp_q,
  input  logic [TH_W-1:0]         thr_det,
  input  logic [TH_W-1:0]         thr_syn,
  output logic                    det_flag,
  output logic                    sync_pulse,
  output logic [IDX_W-1:0]        idx_out
);
  localparam int PW = 2*SMP_W + 1 + $clog2(LAG);

  logic                 c_vld, m_vld, m_qd, m_qs;
  logic signed [PW-1:0] c_pre, c_pim, c_q;
  logic [IDX_W-1:0]     c_idx, m_idx;

  fsd_corr #(.SW(SMP_W), .LAG(LAG), .IDX_W(IDX_W)) u_corr (
    .clk(clk), .rst(rst), .restart(restart),
    .in_vld(smp_vld), .in_re(smp_i), .in_im(smp_q),
    .out_vld(c_vld), .p_re(c_pre), .p_im(c_pim), .q_sum(c_q), .out_idx(c_idx)
  );

  fsd_metric #(.PW(PW), .TH_W(TH_W), .TF(TH_FRAC), .IDX_W(IDX_W)) u_metric (
    .clk(clk), .rst(rst), .restart(restart),
    .in_vld(c_vld), .p_re(c_pre), .p_im(c_pim), .q_sum(c_q), .in_idx(c_idx),
    .thr_det(thr_det), .thr_syn(thr_syn),
    .out_vld(m_vld), .qual_det(m_qd), .qual_syn(m_qs), .out_idx(m_idx)
  );

  fsd_ctrl #(.RUN_LEN(RUN_LEN), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .restart(restart),
    .in_vld(m_vld), .qual_det(m_qd), .qual_syn(m_qs), .in_idx(m_idx),
    .det_flag(det_flag), .sync_pulse(sync_pulse), .idx_out(idx_out)
  );
endmodule

// File: rtl/fsd_chk.sv
module fsd_chk #(
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             restart,
  input logic             smp_vld,
  input logic             det_flag,
  input logic             sync_pulse,
  input logic [IDX_W-1:0] idx_out
);
  logic seen_sync;

  always_ff @(posedge clk) begin
    if (rst || restart) seen_sync <= 1'b0;
    else if (sync_pulse) seen_sync <= 1'b1;
  end

  // R1
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!det_flag && !sync_pulse && idx_out == '0));

  // R5
  sync_single_chk: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> !sync_pulse);

  // R5
  sync_after_det_chk: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> det_flag);

  // R6
  one_sync_chk: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> !seen_sync);

  // R6
  det_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (det_flag && !restart) |=> det_flag);

  // R9
  sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> $past(smp_vld, 3));

  // R9
  det_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(det_flag) |-> $past(smp_vld, 3));
endmodule

bind frame_sync_det fsd_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .restart(restart), .smp_vld(smp_vld),
  .det_flag(det_flag), .sync_pulse(sync_pulse), .idx_out(idx_out)
);

// File: tb/tb_frame_sync_det.sv
module tb_frame_sync_det;
  localparam int CLK_PERIOD = 10;
  localparam int TF = 6;
  localparam int RUN = 48;
  localparam int MAXCYC = 150000;

  logic clk = 1'b0, rst = 1'b1, restart = 1'b0, smp_vld = 1'b0;
  logic signed [11:0] smp_i = '0, smp_q = '0;
  logic [7:0] thr_det = 8'd38, thr_syn = 8'd19;
  logic det_flag, sync_pulse;
  logic [15:0] idx_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_sync_det dut (
    .clk(clk), .rst(rst), .restart(restart), .smp_vld(smp_vld),
    .smp_i(smp_i), .smp_q(smp_q), .thr_det(thr_det), .thr_syn(thr_syn),
    .det_flag(det_flag), .sync_pulse(sync_pulse), .idx_out(idx_out)
  );

  int errors = 0, checks = 0;
  int exp_kind[$];   // 0 = detection, 1 = sync
  int exp_idx[$];
  bit gaps = 1'b0;

  // reference model state
  int mr [0:2047];
  int mi [0:2047];
  int m_t = 0, m_st = 0, m_cnt = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gr(input int t);
    return (t < 0) ? 0 : mr[t];
  endfunction
  function automatic int gi(input int t);
    return (t < 0) ? 0 : mi[t];
  endfunction

  // R2 R3 R4 R5: direct-sum model, independent of running sums
  task automatic model_step(input int re, input int im);
    longint pr = 0, pi = 0, q = 0, lhs;
    mr[m_t] = re;
    mi[m_t] = im;
    for (int m = 0; m < 16; m++) begin
      int ar = gr(m_t-16-m), ai = gi(m_t-16-m);
      int br = gr(m_t-m), bi = gi(m_t-m);
      pr += longint'(ar)*br + longint'(ai)*bi;
      pi += longint'(ar)*bi - longint'(ai)*br;
      q  += longint'(br)*br + longint'(bi)*bi;
    end
    lhs = (pr*pr + pi*pi) * (1 << TF);
    if (m_st == 0) begin
      if (lhs > longint'(thr_det)*q*q) begin
        m_cnt++;
        if (m_cnt == RUN) begin
          m_st = 1;
          exp_kind.push_back(0);
          exp_idx.push_back(m_t);
        end
      end else m_cnt = 0;
    end else if (m_st == 1) begin
      if (lhs < longint'(thr_syn)*q*q) begin
        m_st = 2;
        exp_kind.push_back(1);
        exp_idx.push_back(m_t);
      end
    end
    m_t++;
  endtask

  // driver: one sample, optional idle cycle first (R8)
  task automatic send(input int re, input int im);
    if (gaps && $urandom_range(0, 2) == 0) begin
      @(negedge clk);
      smp_vld = 1'b0;
    end
    @(negedge clk);
    smp_vld = 1'b1;
    smp_i = 12'(re);
    smp_q = 12'(im);
    model_step(re, im);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp_vld = 1'b0;
    end
  endtask

  task automatic noise(input int n, input int amp);
    for (int k = 0; k < n; k++)
      send($urandom_range(0, 2*amp) - amp, $urandom_range(0, 2*amp) - amp);
  endtask

  int base_r [16];
  int base_i [16];
  task automatic new_base(input int amp);
    for (int k = 0; k < 16; k++) begin
      base_r[k] = $urandom_range(0, 2*amp) - amp;
      base_i[k] = $urandom_range(0, 2*amp) - amp;
    end
  endtask
  task automatic preamble(input int n, input int ph);
    for (int k = 0; k < n; k++) send(base_r[(k+ph)%16], base_i[(k+ph)%16]);
  endtask

  task automatic do_restart();
    @(negedge clk);
    smp_vld = 1'b0;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    m_t = 0; m_st = 0; m_cnt = 0;
    chk(det_flag == 1'b0, "R1 det_flag after restart", det_flag, 0);
    chk(sync_pulse == 1'b0, "R1 sync_pulse after restart", sync_pulse, 0);
    chk(idx_out == 16'd0, "R1 idx_out after restart", idx_out, 0);
  endtask

  task automatic drained(input string req);
    idle(8);
    chk(exp_kind.size() == 0, req, exp_kind.size(), 0);
  endtask

  // monitor: pops expected events as the design produces them
  logic prev_det = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (det_flag && !prev_det) begin
        if (exp_kind.size() == 0 || exp_kind[0] != 0)
          chk(1'b0, "R4/R6 unexpected detection", idx_out, -1);
        else begin
          chk(idx_out == 16'(exp_idx[0]), "R4 detection index", idx_out, exp_idx[0]);
          void'(exp_kind.pop_front());
          void'(exp_idx.pop_front());
        end
      end
      if (sync_pulse) begin
        if (exp_kind.size() == 0 || exp_kind[0] != 1)
          chk(1'b0, "R5/R6 unexpected sync", idx_out, -1);
        else begin
          chk(idx_out == 16'(exp_idx[0]), "R5 sync index", idx_out, exp_idx[0]);
          void'(exp_kind.pop_front());
          void'(exp_idx.pop_front());
        end
      end
    end
    prev_det = det_flag;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (MAXCYC) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(det_flag == 1'b0, "R1 det_flag after reset", det_flag, 0);
    chk(sync_pulse == 1'b0, "R1 sync_pulse after reset", sync_pulse, 0);
    chk(idx_out == 16'd0, "R1 idx_out after reset", idx_out, 0);

    // R2 R3 R4 R5 R8: frame with random strobe gaps
    gaps = 1'b1;
    new_base(1000);
    noise(40, 1000);
    preamble(160, 0);
    noise(80, 1000);
    gaps = 1'b0;
    drained("R4/R5 events produced");
    chk(m_st == 2, "R5 frame reached sync", m_st, 2);

    // R6: second preamble after sync is ignored
    new_base(1500);
    preamble(160, 3);
    noise(60, 1200);
    drained("R6 no pending events");
    chk(det_flag == 1'b1, "R6 det_flag held", det_flag, 1);

    // R4: broken run inside a preamble
    do_restart();
    new_base(900);
    noise(20, 900);
    preamble(50, 0);
    send(-base_r[2], -base_i[2]);
    preamble(120, 3);
    noise(60, 900);
    drained("R4 broken run events");

    // R7: full-scale samples
    do_restart();
    thr_det = 8'd32;
    for (int k = 0; k < 100; k++) send(-2048, -2048);
    for (int k = 0; k < 80; k++)
      send(($urandom_range(0, 1) != 0) ? 2047 : -2048, ($urandom_range(0, 1) != 0) ? 2047 : -2048);
    drained("R7 full-scale events");
    chk(m_st == 2, "R7 full-scale frame reached sync", m_st, 2);

    // R3: equality does not qualify for detection
    do_restart();
    thr_det = 8'd64;
    for (int k = 0; k < 120; k++) send(1000, -700);
    drained("R3 no events at equality");
    chk(det_flag == 1'b0, "R3 strict detection compare", det_flag, 0);

    // R5: equality does not qualify for sync
    do_restart();
    thr_det = 8'd32;
    thr_syn = 8'd64;
    for (int k = 0; k < 140; k++) send(-1500, 900);
    drained("R5 detection only at equality");
    chk(det_flag == 1'b1, "R5 detected before sync test", det_flag, 1);
    chk(m_st == 1, "R5 strict sync compare, still waiting", m_st, 1);

    summary();
  end
endmodule